// File: doc/BRIEF.md
# Memory Write Protect and Lock

This block sits on the write path between a bus-side write port and the storage behind it. It checks every write strobe and decides whether it reaches storage. Writes go to one of two spaces, selected per strobe. The first is a memory array of `2**ARRAY_AW` words. The second is a register space that includes the block's own control register.

A 2-bit protect code in the control register sets how much of the array, counted up from address zero, refuses writes. The options are nothing, the lowest quarter, the lowest half, or the whole array. A one-time seal bit in the same register works in one direction only. Once it is set, the serial-number register window becomes read-only, and so does the seal bit itself. Only reset clears the seal bit.

Every write is judged in the cycle its strobe is sampled. The verdict is held in a registered output state machine with four states:
- `V_IDLE`: no strobe was sampled.
- `V_PASS_ARRAY`: an array write was accepted.
- `V_PASS_REG`: a register write was accepted.
- `V_REJECT`: the write was blocked.

The machine moves to the state that matches each sampled strobe and returns to `V_IDLE` when there is no strobe. Accepted writes come out one cycle later as a qualified write enable, with the address and data. A blocked write is dropped silently and raises a one-cycle violation pulse instead.

The seal is a separate two-state machine. It moves from `LK_OPEN` to `LK_SEALED` when a control-register write carries a 1 in the seal bit. It has no transition out of `LK_SEALED` except reset.

Top module: `wp_write_gate`

## Requirements
- R1: Reset sets all of the following to 0: `mem_we`, `reg_we` and `wr_violation`; the protect code (`prot_code` = 00); and the seal (`lock_set` = 0).
- R2: With protect code 00, every array write to an address below DEPTH (64 by default) is accepted. One cycle after the sampled strobe, `mem_we`=1, with `out_addr` and `out_data` equal to the written address and data.
- R3: With protect code 01, array writes to addresses below DEPTH/4 are blocked. Writes from DEPTH/4 up to DEPTH-1 are accepted.
- R4: With protect code 10, array writes to addresses below DEPTH/2 are blocked. Writes from DEPTH/2 up to DEPTH-1 are accepted.
- R5: With protect code 11, every array write is blocked.
- R6: An array write whose address is DEPTH or higher is blocked, whatever the protect code.
- R7: A register write to the control register (address 0Bh) that has data bit 7 = 1 sets the seal (`lock_set`=1). From the next write on, register writes to addresses 11h through 18h are blocked. Other register addresses stay writable.
- R8: Once the seal is set, only reset clears it. A control-register write with bit 7 = 0 leaves `lock_set`=1, and its forwarded `out_data` has bit 7 forced to 1.
- R9: Control-register bits [3:2] load the protect code on every control-register write. This holds whether or not the block is sealed and whatever the current protect code is. The control write itself is forwarded with `reg_we`.
- R10: A blocked write produces exactly one cycle of `wr_violation`, and no `mem_we` or `reg_we` in that cycle. `wr_violation` and either write enable are never high together.
- R11: Before the seal is set, register writes to every address, including 11h through 18h, are accepted.
- R12: A cycle with no sampled strobe produces neither write enable nor `wr_violation` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe, one write per sampled cycle |
| wr_is_array | input | 1 | 1 selects the memory array, 0 the register space |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| mem_we | output | 1 | Qualified array write enable |
| reg_we | output | 1 | Qualified register write enable |
| out_addr | output | ADDR_W | Address of the qualified write |
| out_data | output | DATA_W | Data of the qualified write (seal bit forced when sealed) |
| wr_violation | output | 1 | One-cycle pulse for a dropped write |
| prot_code | output | 2 | Current array protect code |
| lock_set | output | 1 | Seal state |

## Verification
The assertions check the following on every cycle:
- Violation and the write enables are mutually exclusive.
- The seal never falls while reset is inactive.
- A full-array code always rejects array writes.
- A sealed serial-window write always rejects.
- An idle cycle leads to an idle verdict.
- A control write always loads the protect code.

Only the bench's scenarios can show the exact quarter and half boundary addresses and the out-of-range addresses. The same holds for the forwarded address and data, the register sweeps before and after sealing, and the clearing of the seal by reset.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        PR_NONE    = 2'b00,
        PR_QUARTER = 2'b01,
        PR_HALF    = 2'b10,
        PR_ALL     = 2'b11
    } prot_t;

    typedef enum logic [1:0] {
        V_IDLE,
        V_PASS_ARRAY,
        V_PASS_REG,
        V_REJECT
    } verdict_t;

    typedef enum logic {
        LK_OPEN,
        LK_SEALED
    } lock_state_t;

endpackage

// File: rtl/wp_array_guard.sv
module wp_array_guard
    import wp_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int ARRAY_AW = 6
) (
    input  prot_t             prot,
    input  logic [ADDR_W-1:0] addr,
    output logic              ok
);
    localparam int DEPTH = 1 << ARRAY_AW;
    localparam int LIM_W = ARRAY_AW + 1;
    localparam int QTR   = DEPTH / 4;
    localparam int HALF  = DEPTH / 2;

    logic             in_range;
    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] low_addr;

    generate
        if (ADDR_W > ARRAY_AW) begin : g_wide
            assign in_range = ~|addr[ADDR_W-1:ARRAY_AW];
        end else begin : g_exact
            assign in_range = 1'b1;
        end
    endgenerate

    assign low_addr = {1'b0, addr[ARRAY_AW-1:0]};

    always_comb begin
        unique case (prot)
            PR_NONE:    limit = '0;
            PR_QUARTER: limit = LIM_W'(QTR);
            PR_HALF:    limit = LIM_W'(HALF);
            PR_ALL:     limit = LIM_W'(DEPTH);
            default:    limit = LIM_W'(DEPTH);
        endcase
    end

    assign ok = in_range && (low_addr >= limit);

endmodule

// File: rtl/wp_reg_guard.sv
module wp_reg_guard #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0B,
    parameter logic [ADDR_W-1:0] SER_FIRST = 8'h11,
    parameter logic [ADDR_W-1:0] SER_LAST  = 8'h18,
    parameter int                LOCK_BIT  = 7
) (
    input  logic              locked,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              ok,
    output logic              ctrl_hit,
    output logic [DATA_W-1:0] data_out
);
    logic in_window;

    assign in_window = (addr >= SER_FIRST) && (addr <= SER_LAST);
    assign ctrl_hit  = (addr == CTRL_ADDR);
    assign ok        = !(locked && in_window);

    always_comb begin
        data_out = data;
        if (ctrl_hit && locked) begin
            data_out[LOCK_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/wp_lock_fsm.sv
module wp_lock_fsm
    import wp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seal_req,
    output logic locked
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            LK_OPEN:   state_d = seal_req ? LK_SEALED : LK_OPEN;
            LK_SEALED: state_d = LK_SEALED;
            default:   state_d = LK_SEALED;
        endcase
    end

    assign locked = (state_q == LK_SEALED);

    // R8: the seal never falls while reset is inactive
    a_r8_seal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SEALED) |=> (state_q == LK_SEALED));

    // R7: a seal request in the open state seals on the next edge
    a_r7_seal_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (seal_req && state_q == LK_OPEN) |=> locked);

endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate
    import wp_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter int                ARRAY_AW  = 6,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0B,
    parameter logic [ADDR_W-1:0] SER_FIRST = 8'h11,
    parameter logic [ADDR_W-1:0] SER_LAST  = 8'h18,
    parameter int                LOCK_BIT  = 7,
    parameter int                PROT_LSB  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              wr_is_array,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mem_we,
    output logic              reg_we,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic              wr_violation,
    output logic [1:0]        prot_code,
    output logic              lock_set
);
    prot_t             prot_q;
    logic              locked;
    logic              arr_ok;
    logic              reg_ok;
    logic              ctrl_hit;
    logic              ctrl_wr;
    logic              seal_req;
    logic [DATA_W-1:0] reg_data;

    verdict_t          verdict_q, verdict_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    wp_array_guard #(
        .ADDR_W   (ADDR_W),
        .ARRAY_AW (ARRAY_AW)
    ) u_array_guard (
        .prot (prot_q),
        .addr (wr_addr),
        .ok   (arr_ok)
    );

    wp_reg_guard #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR),
        .SER_FIRST (SER_FIRST),
        .SER_LAST  (SER_LAST),
        .LOCK_BIT  (LOCK_BIT)
    ) u_reg_guard (
        .locked   (locked),
        .addr     (wr_addr),
        .data     (wr_data),
        .ok       (reg_ok),
        .ctrl_hit (ctrl_hit),
        .data_out (reg_data)
    );

    assign ctrl_wr  = wr_stb && !wr_is_array && ctrl_hit;
    assign seal_req = ctrl_wr && wr_data[LOCK_BIT];

    wp_lock_fsm u_lock_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .seal_req (seal_req),
        .locked   (locked)
    );

    // Protect field: always writable through the control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= PR_NONE;
        end else if (ctrl_wr) begin
            prot_q <= prot_t'(wr_data[PROT_LSB +: 2]);
        end
    end

    // Verdict for the strobe sampled this cycle
    always_comb begin
        if (!wr_stb) begin
            verdict_d = V_IDLE;
        end else if (wr_is_array) begin
            verdict_d = arr_ok ? V_PASS_ARRAY : V_REJECT;
        end else begin
            verdict_d = reg_ok ? V_PASS_REG : V_REJECT;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= V_IDLE;
            addr_q    <= '0;
            data_q    <= '0;
        end else begin
            verdict_q <= verdict_d;
            if (wr_stb) begin
                addr_q <= wr_addr;
                data_q <= wr_is_array ? wr_data : reg_data;
            end
        end
    end

    // Outputs decoded from the verdict state
    always_comb begin
        mem_we       = 1'b0;
        reg_we       = 1'b0;
        wr_violation = 1'b0;
        unique case (verdict_q)
            V_IDLE:       ;
            V_PASS_ARRAY: mem_we       = 1'b1;
            V_PASS_REG:   reg_we       = 1'b1;
            V_REJECT:     wr_violation = 1'b1;
            default:      ;
        endcase
    end

    assign out_addr  = addr_q;
    assign out_data  = data_q;
    assign prot_code = prot_q;
    assign lock_set  = locked;

    // R10: a violation never coincides with a write enable
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_violation && (mem_we || reg_we)));

    // R5: full-array code rejects every array write
    a_r5_full_block: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_is_array && prot_q == PR_ALL) |=> (wr_violation && !mem_we));

    // R7: sealed serial-window writes are rejected
    a_r7_window_block: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_is_array && lock_set && wr_addr >= SER_FIRST && wr_addr <= SER_LAST)
        |=> (wr_violation && !reg_we));

    // R12: no strobe, no activity
    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> !(mem_we || reg_we || wr_violation));

    // R9: control write loads the protect code regardless of seal
    a_r9_prot_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (prot_code == $past(wr_data[PROT_LSB +: 2])));

endmodule

// File: tb/wp_write_gate_test.sv
module wp_write_gate_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic       wr_is_array = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       mem_we, reg_we, wr_violation, lock_set;
    logic [7:0] out_addr, out_data;
    logic [1:0] prot_code;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;

    int  exp_code = 0;
    bit  exp_lock = 0;

    always #2 clk = ~clk;

    wp_write_gate uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb       (wr_stb),
        .wr_is_array  (wr_is_array),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .mem_we       (mem_we),
        .reg_we       (reg_we),
        .out_addr     (out_addr),
        .out_data     (out_data),
        .wr_violation (wr_violation),
        .prot_code    (prot_code),
        .lock_set     (lock_set)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    task automatic wr(input bit arr, input int a, input int d, input string req);
        bit         blocked;
        int         lim;
        logic [2:0] ev;
        int         ed;
        @(negedge clk);
        wr_stb      = 1'b1;
        wr_is_array = arr;
        wr_addr     = a[7:0];
        wr_data     = d[7:0];
        @(posedge clk);
        #1;
        lim = (exp_code == 0) ? 0 : (exp_code == 1) ? 16 : (exp_code == 2) ? 32 : 64;
        if (arr) blocked = (a >= 64) || (a < lim);
        else     blocked = exp_lock && (a >= 'h11) && (a <= 'h18);
        ev = blocked ? 3'b001 : (arr ? 3'b100 : 3'b010);
        chk({mem_we, reg_we, wr_violation} == ev, req, {mem_we, reg_we, wr_violation}, ev);
        if (!blocked) begin
            ed = d & 'hFF;
            if (!arr && a == 'h0B && exp_lock) ed = ed | 'h80;
            chk(out_addr == a[7:0] && out_data == ed[7:0], req,
                {out_addr, out_data}, {a[7:0], ed[7:0]});
        end
        if (!arr && a == 'h0B) begin
            exp_code = (d >> 2) & 3;
            if (d[7]) exp_lock = 1;
        end
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        #1;
        chk({mem_we, reg_we, wr_violation, prot_code, lock_set} == 6'b0, "R1 reset state",
            {mem_we, reg_we, wr_violation, prot_code, lock_set}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: idle cycles
        repeat (4) begin
            @(posedge clk);
            #1;
            chk({mem_we, reg_we, wr_violation} == 3'b0, "R12 idle", {mem_we, reg_we, wr_violation}, 0);
        end

        // R2..R6: array sweep under each protect code
        for (int c = 0; c < 4; c++) begin
            wr(0, 'h0B, c << 2, "R9 set code");
            chk(prot_code == c[1:0], "R9 prot code", prot_code, c);
            tag = (c == 0) ? "R2 open array" : (c == 1) ? "R3 quarter" :
                  (c == 2) ? "R4 half" : "R5 full";
            for (int a = 0; a < 256; a++) begin
                wr(1, a, a ^ 'h5A, (a >= 64) ? "R6 out of range R10" : tag);
            end
        end

        // R11: register sweep before seal
        wr(0, 'h0B, 0, "R9 clear code");
        for (int a = 0; a < 256; a++) begin
            if (a != 'h0B) wr(0, a, a ^ 'hC3, "R11 unsealed register");
        end

        // R7: seal, then sweep
        wr(0, 'h0B, 'h80 | (1 << 2), "R7 seal write");
        chk(lock_set == 1'b1, "R7 lock_set", lock_set, 1);
        for (int a = 0; a < 256; a++) begin
            if (a != 'h0B) wr(0, a, a ^ 'h3C, "R7 sealed register R10");
        end

        // R8/R9: seal bit cannot be cleared, protect bits still writable
        wr(0, 'h0B, 2 << 2, "R8 clear attempt");
        chk(lock_set == 1'b1, "R8 seal sticky", lock_set, 1);
        chk(prot_code == 2'b10, "R9 code while sealed", prot_code, 2);
        wr(0, 'h0B, 3 << 2, "R9 code full");
        wr(1, 40, 7, "R5 full sealed");
        wr(0, 'h0B, 0, "R9 code from full");
        chk(prot_code == 2'b00, "R9 code cleared under full", prot_code, 0);
        wr(1, 0, 9, "R2 after reopen");
        wr(0, 'h14, 1, "R7 window still sealed");

        // R12: idle after activity
        repeat (3) begin
            @(posedge clk);
            #1;
            chk({mem_we, reg_we, wr_violation} == 3'b0, "R12 idle later",
                {mem_we, reg_we, wr_violation}, 0);
        end

        // R1: reset clears the seal
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk({prot_code, lock_set} == 3'b0, "R1 reset clears seal", {prot_code, lock_set}, 0);
        @(negedge clk);
        rst_n    = 1'b1;
        exp_code = 0;
        exp_lock = 0;
        wr(0, 'h11, 'hAA, "R11 window open after reset");
        wr(0, 'h18, 'h55, "R11 window top after reset");

        summary();
    end

endmodule